// File: doc/BRIEF.md
# Indirectly Programmed Event Counter Bank

This block holds a bank of eight 32-bit event counters for profiling a processor core. On every clock cycle the core reports which events occurred, as one strobe per event code. Accesses to the context identifier register arrive as a separate read strobe and write strobe. Each counter is assigned an event code and increments by one in any cycle in which that code's event occurs, provided the counter's own enable bit is set and the bank's global enable is on.

Software programs the bank over a simple single-cycle register bus. Per-counter enables are set and cleared through two write-one-to-act registers. The event code of a counter is not written directly. Software first names the counter in a select register, and a single event-type register then acts on the counter that was named. The counters themselves can be read and written at fixed word addresses.

The event code for a context-identifier write is counted only from the write strobe. A read of that register never counts, and the core's own strobe in that code slot is ignored. The bank also drives a registered pulse vector with one bit per event code, which follows the same rule.

Top module: `evt_count_bank`

## Requirements
- R1: After reset, all counters read 0, both enable registers read 0, the control word reads 0, the select register reads 0, every counter's event code reads 0 and every pulse output bit is 0.
- R2: A bus write to word 1 sets each per-counter enable bit whose data bit is 1 and leaves the bits written with 0 unchanged. Reading word 1 or word 2 returns the enable mask in bits 7:0.
- R3: A bus write to word 2 clears each per-counter enable bit whose data bit is 1 and leaves the others unchanged.
- R4: Word 3 holds a 5-bit counter index (bits 4:0). Reads and writes of word 4 (event code, bits 7:0) act on the counter named by that index.
- R5: When the index in word 3 is 8 or greater, reads of word 4 return 0 and writes to word 4 change no counter's event code.
- R6: A counter increments by exactly one at the clock edge that samples its event strobe, when its enable bit and the global enable are both 1. Its new value is visible after that edge. Event codes 16 and above never match.
- R7: While the global enable (word 0, bit 0) is 0, no counter changes except through a bus write or a clear.
- R8: A counter programmed with code 0x0B counts only context-identifier write strobes. The context-identifier read strobe and the core's own strobe for code 0x0B have no effect on it.
- R9: Pulse output bit c+1 is high for the cycle after the edge that sampled the event for code c. Bit 12 (code 0x0B) follows only the context-identifier write strobe, and bit 0 is always 0.
- R10: A counter at 0xFFFFFFFF wraps to 0 on its next increment and then continues counting from 0.
- R11: Writing 1 to word 0, bit 1, zeroes all counters at that edge, and the clear wins over a coincident increment. That bit reads back as 0, and word 0, bit 0 reads back the global enable.
- R12: Counter i is read and written at word 8+i. A bus write to a counter in the same cycle as its increment leaves exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data, combinational, 0 when not reading |
| core_evt | input | NUM_CODES (16) | One strobe per event code in this cycle |
| ctxid_wr | input | 1 | Context identifier register written this cycle |
| ctxid_rd | input | 1 | Context identifier register read this cycle |
| evt_pulse | output | NUM_CODES+1 (17) | Registered event pulses, bit c+1 for code c |

## Verification
Two functions can land on the same counter in the same cycle: an event increment, and a software action on that counter, which is either a direct counter write or a bank-wide clear. The bench provokes this by issuing the write or the clear while holding the counter's event strobe high. It then reads the counter back and expects the written value or zero, never that value plus one. A second collision involves the context-identifier read and write strobes together with the core's strobe for code 0x0B, asserted alone and in combination. A behavioural model applies the same priorities and is compared against the read data and the pulse vector on every clock.

// File: rtl/epc_pkg.sv
package epc_pkg;

    // Word addresses of the configuration registers (counters sit in the upper half)
    localparam int REG_CTRL   = 0;
    localparam int REG_EN_SET = 1;
    localparam int REG_EN_CLR = 2;
    localparam int REG_SEL    = 3;
    localparam int REG_TYPE   = 4;

    // Control word bit positions
    localparam int CTRL_GLOB_BIT = 0;
    localparam int CTRL_CLR_BIT  = 1;

    // Event code that stands for a write to the context identifier register
    localparam int CODE_CTX_WR = 11;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_WRITE
    } bus_op_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_LOAD,
        ACT_ZERO
    } ctr_act_e;

endpackage

// File: rtl/epc_event_map.sv
module epc_event_map #(
    parameter int NUM_CODES = 16,
    parameter int CTX_CODE  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CODES-1:0] core_evt,
    input  logic                 ctxid_wr,
    input  logic                 ctxid_rd,
    output logic [NUM_CODES-1:0] hit,
    output logic [NUM_CODES:0]   pulse_q
);

    // Per-code source selection: the context-ID code slot is fed from the write strobe only
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
        if (c == CTX_CODE) begin : g_ctx
            logic unused_ctx_src;
            assign unused_ctx_src = core_evt[c] ^ ctxid_rd;
            assign hit[c] = ctxid_wr;

            // R8: a read of the context identifier alone never raises its pulse
            p_ctx_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (ctxid_rd && !ctxid_wr) |=> !pulse_q[c+1]);

            // R8: a write always raises it
            p_ctx_write_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ctxid_wr |=> pulse_q[c+1]);
        end else begin : g_core
            assign hit[c] = core_evt[c];

            // R9: core strobe for code c shows at bit c+1 one cycle later
            p_pulse_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
                core_evt[c] |=> pulse_q[c+1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= {hit, 1'b0};
        end
    end

endmodule

// File: rtl/epc_counter.sv
module epc_counter
    import epc_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int CODE_W    = 8,
    parameter int NUM_CODES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glob_en,
    input  logic                 ctr_en,
    input  logic [CODE_W-1:0]    code,
    input  logic [NUM_CODES-1:0] hit,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [CNT_W-1:0]     wdata,
    output logic [CNT_W-1:0]     cnt_q
);

    logic     code_hit;
    ctr_act_e act;

    // Pick this counter's event out of the per-code strobes
    always_comb begin
        code_hit = 1'b0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (code == CODE_W'(c)) begin
                code_hit = hit[c];
            end
        end
    end

    // Priority: clear, then software load, then increment
    always_comb begin
        if (clr) begin
            act = ACT_ZERO;
        end else if (wr) begin
            act = ACT_LOAD;
        end else if (glob_en && ctr_en && code_hit) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_ZERO: cnt_q <= '0;
                ACT_LOAD: cnt_q <= wdata;
                ACT_STEP: cnt_q <= cnt_q + CNT_W'(1);
                ACT_HOLD: cnt_q <= cnt_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && ctr_en && code_hit && !clr && !wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !clr && !wr) |=> $stable(cnt_q));

    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/epc_cfg_regs.sv
module epc_cfg_regs
    import epc_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CODE_W  = 8,
    parameter int SEL_W   = 5,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic [NUM_CTR-1:0][DATA_W-1:0]    cnt_all,
    output logic                              glob_en,
    output logic [NUM_CTR-1:0]                ctr_en,
    output logic [NUM_CTR-1:0][CODE_W-1:0]    codes,
    output logic                              clr,
    output logic [NUM_CTR-1:0]                ctr_wr,
    output logic [DATA_W-1:0]                 bus_rdata
);

    localparam int IDX_W = ADDR_W - 1;

    bus_op_e                         op;
    logic                            glob_q;
    logic [NUM_CTR-1:0]              en_q;
    logic [SEL_W-1:0]                sel_q;
    logic [NUM_CTR-1:0][CODE_W-1:0]  codes_q;
    logic                            sel_ok;
    logic [IDX_W-1:0]                sel_idx;
    logic                            ctr_space;
    logic                            unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        if (!bus_sel) begin
            op = OP_IDLE;
        end else if (bus_wr) begin
            op = OP_WRITE;
        end else begin
            op = OP_READ;
        end
    end

    assign ctr_space = bus_addr[ADDR_W-1];
    assign sel_ok    = (sel_q < SEL_W'(NUM_CTR));
    assign sel_idx   = sel_q[IDX_W-1:0];

    // Register file writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q  <= 1'b0;
            en_q    <= '0;
            sel_q   <= '0;
            codes_q <= '0;
        end else if (op == OP_WRITE && !ctr_space) begin
            case (bus_addr)
                ADDR_W'(REG_CTRL):   glob_q <= bus_wdata[CTRL_GLOB_BIT];
                ADDR_W'(REG_EN_SET): en_q   <= en_q | bus_wdata[NUM_CTR-1:0];
                ADDR_W'(REG_EN_CLR): en_q   <= en_q & ~bus_wdata[NUM_CTR-1:0];
                ADDR_W'(REG_SEL):    sel_q  <= bus_wdata[SEL_W-1:0];
                ADDR_W'(REG_TYPE): begin
                    if (sel_ok) begin
                        codes_q[sel_idx] <= bus_wdata[CODE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    assign clr = (op == OP_WRITE) && (bus_addr == ADDR_W'(REG_CTRL)) && bus_wdata[CTRL_CLR_BIT];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_wr
        assign ctr_wr[i] = (op == OP_WRITE) && ctr_space && (bus_addr[IDX_W-1:0] == IDX_W'(i));
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (op == OP_READ) begin
            if (ctr_space) begin
                bus_rdata = cnt_all[bus_addr[IDX_W-1:0]];
            end else begin
                case (bus_addr)
                    ADDR_W'(REG_CTRL):   bus_rdata[CTRL_GLOB_BIT] = glob_q;
                    ADDR_W'(REG_EN_SET),
                    ADDR_W'(REG_EN_CLR): bus_rdata[NUM_CTR-1:0] = en_q;
                    ADDR_W'(REG_SEL):    bus_rdata[SEL_W-1:0] = sel_q;
                    ADDR_W'(REG_TYPE): begin
                        if (sel_ok) begin
                            bus_rdata[CODE_W-1:0] = codes_q[sel_idx];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign glob_en = glob_q;
    assign ctr_en  = en_q;
    assign codes   = codes_q;

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && bus_addr == ADDR_W'(REG_EN_SET))
        |=> (en_q == ($past(en_q) | $past(bus_wdata[NUM_CTR-1:0]))));

    p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && bus_addr == ADDR_W'(REG_EN_CLR))
        |=> ((en_q & $past(bus_wdata[NUM_CTR-1:0])) == '0));

    p_type_oob_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && bus_addr == ADDR_W'(REG_TYPE) && !sel_ok) |=> $stable(codes_q));

    p_type_oob_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && bus_addr == ADDR_W'(REG_TYPE) && !sel_ok) |-> (bus_rdata == '0));

endmodule

// File: rtl/evt_count_bank.sv
module evt_count_bank
    import epc_pkg::*;
#(
    parameter int NUM_CTR   = 8,
    parameter int NUM_CODES = 16,
    parameter int CNT_W     = 32,
    parameter int CODE_W    = 8,
    parameter int SEL_W     = 5,
    parameter int ADDR_W    = $clog2(NUM_CTR) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic [NUM_CODES-1:0] core_evt,
    input  logic                 ctxid_wr,
    input  logic                 ctxid_rd,
    output logic [NUM_CODES:0]   evt_pulse
);

    logic                             glob_en;
    logic [NUM_CTR-1:0]               ctr_en;
    logic [NUM_CTR-1:0][CODE_W-1:0]   codes;
    logic                             clr;
    logic [NUM_CTR-1:0]               ctr_wr;
    logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_all;
    logic [NUM_CODES-1:0]             hit;

    epc_event_map #(
        .NUM_CODES (NUM_CODES),
        .CTX_CODE  (CODE_CTX_WR)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_evt (core_evt),
        .ctxid_wr (ctxid_wr),
        .ctxid_rd (ctxid_rd),
        .hit      (hit),
        .pulse_q  (evt_pulse)
    );

    epc_cfg_regs #(
        .NUM_CTR (NUM_CTR),
        .CODE_W  (CODE_W),
        .SEL_W   (SEL_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (CNT_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_all   (cnt_all),
        .glob_en   (glob_en),
        .ctr_en    (ctr_en),
        .codes     (codes),
        .clr       (clr),
        .ctr_wr    (ctr_wr),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        epc_counter #(
            .CNT_W     (CNT_W),
            .CODE_W    (CODE_W),
            .NUM_CODES (NUM_CODES)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .glob_en (glob_en),
            .ctr_en  (ctr_en[i]),
            .code    (codes[i]),
            .hit     (hit),
            .clr     (clr),
            .wr      (ctr_wr[i]),
            .wdata   (bus_wdata),
            .cnt_q   (cnt_all[i])
        );
    end

    // R9: the lowest pulse bit carries no event
    p_pulse_low_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel || !bus_sel) |=> !evt_pulse[0]);

endmodule

// File: tb/test_evt_count_bank.sv
module test_evt_count_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] core_evt;
    logic        ctxid_wr, ctxid_rd;
    logic [16:0] evt_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model state
    logic [31:0] m_cnt [8];
    logic [7:0]  m_type [8];
    logic [7:0]  m_en;
    logic        m_glob;
    logic [4:0]  m_sel;
    logic [16:0] m_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_count_bank i_evt_count_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_evt  (core_evt),
        .ctxid_wr  (ctxid_wr),
        .ctxid_rd  (ctxid_rd),
        .evt_pulse (evt_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_cnt[i]  = '0;
            m_type[i] = '0;
        end
        m_en = '0; m_glob = 1'b0; m_sel = '0; m_pulse = '0;
    endtask

    function automatic logic [31:0] model_read();
        logic [31:0] r;
        r = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr >= 4'd8) r = m_cnt[bus_addr - 4'd8];
            else case (bus_addr)
                4'd0: r = {31'b0, m_glob};
                4'd1, 4'd2: r = {24'b0, m_en};
                4'd3: r = {27'b0, m_sel};
                4'd4: r = (m_sel < 5'd8) ? {24'b0, m_type[m_sel[2:0]]} : 32'h0;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    task automatic model_step();
        logic [15:0] hits;
        logic        inc [8];
        logic        clr;
        hits     = core_evt;
        hits[11] = ctxid_wr;
        for (int i = 0; i < 8; i++) begin
            inc[i] = m_glob && m_en[i] && (m_type[i] < 8'd16) && hits[m_type[i][3:0]];
        end
        clr = bus_sel && bus_wr && (bus_addr == 4'd0) && bus_wdata[1];
        for (int i = 0; i < 8; i++) begin
            if (clr) m_cnt[i] = '0;
            else if (bus_sel && bus_wr && bus_addr == 4'(8 + i)) m_cnt[i] = bus_wdata;
            else if (inc[i]) m_cnt[i] = m_cnt[i] + 32'd1;
        end
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                4'd0: m_glob = bus_wdata[0];
                4'd1: m_en = m_en | bus_wdata[7:0];
                4'd2: m_en = m_en & ~bus_wdata[7:0];
                4'd3: m_sel = bus_wdata[4:0];
                4'd4: if (m_sel < 5'd8) m_type[m_sel[2:0]] = bus_wdata[7:0];
                default: ;
            endcase
        end
        m_pulse = {hits, 1'b0};
    endtask

    // One clock: drive, advance the model at the edge, compare half a period later
    task automatic cyc(input logic s, input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [15:0] ev, input logic cw, input logic cr, input string tag);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        core_evt = ev; ctxid_wr = cw; ctxid_rd = cr;
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/2);
        chk({tag, " pulse"}, {15'b0, evt_pulse}, {15'b0, m_pulse});
        chk({tag, " rdata"}, bus_rdata, model_read());
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 16'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b1, 1'b0, a, 32'h0, 16'h0, 1'b0, 1'b0, tag);
        chk({tag, " literal"}, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        logic [7:0]  codes [8];
        codes = '{8'h01, 8'h02, 8'h03, 8'h0B, 8'h05, 8'h06, 8'h07, 8'h20};
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        core_evt = 0; ctxid_wr = 0; ctxid_rd = 0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        chk("R1 pulse in reset", {15'b0, evt_pulse}, 32'h0);
        rst_n = 1'b1;

        // R1: reset contents
        rd(4'd0, 32'h0, "R1 ctrl");
        rd(4'd1, 32'h0, "R1 enable");
        rd(4'd3, 32'h0, "R1 select");
        rd(4'd4, 32'h0, "R1 type");
        for (int i = 8; i < 16; i++) rd(4'(i), 32'h0, "R1 counter");

        // R2 / R3: enable set and clear
        wr(4'd1, 32'h05, "R2");
        wr(4'd1, 32'h30, "R2");
        wr(4'd1, 32'h00, "R2");
        rd(4'd1, 32'h35, "R2 set word");
        rd(4'd2, 32'h35, "R2 clr word");
        wr(4'd2, 32'h11, "R3");
        rd(4'd1, 32'h24, "R3");
        rd(4'd2, 32'h24, "R3");

        // R4: indirect event-code programming
        for (int i = 0; i < 8; i++) begin
            wr(4'd3, 32'(i), "R4");
            wr(4'd4, {24'h0, codes[i]}, "R4");
        end
        for (int i = 0; i < 8; i++) begin
            wr(4'd3, 32'(i), "R4");
            rd(4'd4, {24'h0, codes[i]}, "R4 readback");
        end

        // R5: out-of-range select
        wr(4'd3, 32'd9, "R5");
        wr(4'd4, 32'h04, "R5");
        rd(4'd4, 32'h0, "R5 read zero");
        rd(4'd3, 32'd9, "R5 select holds");
        for (int i = 0; i < 8; i++) begin
            wr(4'd3, 32'(i), "R5");
            rd(4'd4, {24'h0, codes[i]}, "R5 codes untouched");
        end

        // R6: counting with random events
        wr(4'd1, 32'hFF, "R6");
        wr(4'd0, 32'h1, "R6");
        for (int k = 0; k < 60; k++) begin
            cyc(1'b1, 1'b0, 4'(8 + (k % 8)), 32'h0, 16'($urandom), 1'($urandom), 1'($urandom), "R6");
        end

        // R7: global enable off
        wr(4'd0, 32'h0, "R7");
        for (int k = 0; k < 30; k++) begin
            cyc(1'b1, 1'b0, 4'(8 + (k % 8)), 32'h0, 16'hFFFF, 1'b1, 1'b0, "R7");
        end

        // R8: context-ID counter (counter 3, code 0x0B)
        wr(4'd0, 32'h1, "R8");
        cyc(1'b1, 1'b0, 4'd11, 32'h0, 16'h0, 1'b0, 1'b0, "R8");
        base = bus_rdata;
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 4'd11, 32'h0, 16'h0, 1'b0, 1'b1, "R8 read strobe");
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 4'd11, 32'h0, 16'h0800, 1'b0, 1'b0, "R8 core slot");
        cyc(1'b1, 1'b0, 4'd11, 32'h0, 16'h0800, 1'b0, 1'b1, "R8 both");
        rd(4'd11, base, "R8 no count on read");
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 4'd11, 32'h0, 16'h0, 1'b1, 1'b0, "R8 write strobe");
        rd(4'd11, base + 32'd3, "R8 counts writes");

        // R9: pulse mapping
        for (int c = 0; c < 16; c++) begin
            cyc(1'b0, 1'b0, 4'd0, 32'h0, 16'(1 << c), 1'b0, 1'b1, "R9");
            chk("R9 literal", {15'b0, evt_pulse}, (c == 11) ? 32'h0 : 32'(1 << (c + 1)));
        end
        cyc(1'b0, 1'b0, 4'd0, 32'h0, 16'h0, 1'b1, 1'b0, "R9");
        chk("R9 ctx write bit", {15'b0, evt_pulse}, 32'h1000);

        // R10: wrap (counter 0, code 1)
        wr(4'd8, 32'hFFFF_FFFE, "R10");
        cyc(1'b1, 1'b0, 4'd8, 32'h0, 16'h0002, 1'b0, 1'b0, "R10");
        chk("R10 top", bus_rdata, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 4'd8, 32'h0, 16'h0002, 1'b0, 1'b0, "R10");
        chk("R10 wrap", bus_rdata, 32'h0);
        cyc(1'b1, 1'b0, 4'd8, 32'h0, 16'h0002, 1'b0, 1'b0, "R10");
        chk("R10 after wrap", bus_rdata, 32'h1);

        // R11: clear with all events active
        cyc(1'b1, 1'b1, 4'd0, 32'h3, 16'hFFFF, 1'b1, 1'b0, "R11");
        for (int i = 8; i < 16; i++) rd(4'(i), 32'h0, "R11 cleared");
        rd(4'd0, 32'h1, "R11 ctrl readback");

        // R12: software write collides with increment (counter 1, code 2)
        cyc(1'b1, 1'b1, 4'd9, 32'h0000_1234, 16'h0004, 1'b0, 1'b0, "R12");
        rd(4'd9, 32'h0000_1234, "R12 write wins");

        // Mixed traffic
        for (int k = 0; k < 3000; k++) begin
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0), 4'($urandom),
                ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 31)) : 32'($urandom),
                16'($urandom), 1'($urandom), 1'($urandom), "R12 mix");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule